// File: doc/BRIEF.md
# Per-Line Configurable Interrupt Detector

This block turns a wide vector of sampled input lines into per-line interrupt status. Each line can trigger on an edge or a level, with a chosen polarity, or on any change. Lines are grouped into 32-line banks. Each bank has five 32-bit registers: an enable mask, three sense-mode masks and a status register. Software clears status by writing ones to it. All banks drive one shared interrupt output.

Software reaches the registers through a simple memory-mapped port. Writes take effect on the clock edge. Reads are combinational from the address. A separate serialiser, outside this block, delivers the inputs as a parallel vector with a one-cycle valid strobe. Edges are found by comparing each valid sample with the sample before it.

Top module: `line_irq_detector`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is low. Mode 0 in all three sense masks means single falling edge.
- R2: Register addresses are byte addresses. The bank index is `reg_addr[ADDR_W-1:5]`, so banks are 0x20 apart. Within a bank, `reg_addr[4:2]` selects the register: 0 enable, 1 polarity, 2 level, 3 both-edge, 4 status. Offsets 5 to 7 and nonexistent banks read 0 and ignore writes. Line n sits in bank n/32 at bit n%32. The enable and mode registers read back what was written.
- R3: In edge mode (level bit 0, both bit 0), polarity bit 0 detects a 1-to-0 change between two consecutive valid samples. Polarity bit 1 detects a 0-to-1 change. Any other pair of samples detects nothing.
- R4: When the both bit is 1 and the level bit is 0, any change between consecutive valid samples is detected, whatever the polarity bit says. No change is never detected.
- R5: When the level bit is 1, every valid sample equal to the polarity bit sets status. The both bit has no effect in level mode.
- R6: A status bit is set only for an enabled line and only on a cycle where `smp_valid` is 1. Input changes without the strobe are not remembered as events.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: If a detection and a clear of the same bit happen in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when some line has both its status bit and its enable bit set, in any bank. Clearing the enable masks `irq` but leaves the status bit in place.
- R10: The first valid sample after reset only records the reference values. No edge is detected on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Marks `smp_data` as a new sample |
| smp_data | input | NUM_BANKS*32 | Parallel line samples; bit n is line n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Aggregated interrupt |

## Verification
The hardest case to reach from the ports is a status clear landing in the same cycle as a new detection on the same line. The bench gets there by driving a status write and a valid sample in one clock. It does this twice: once with the line active in level mode, where the bit must survive, and once with the line inactive, where the bit must clear. The first-sample rule is reached only right after reset. So a directed segment resets the block, arms a rising-edge line and presents a high sample first. Edge cases that need a particular previous sample are laid out in the table as pairs of samples, with the status cleared between the two.

// File: rtl/lid_pkg.sv
package lid_pkg;
    localparam int BANK_W = 32;
    localparam int REG_AW = 5;   // byte offset bits inside one bank window

    typedef enum logic [2:0] {
        SEL_ENABLE = 3'd0,
        SEL_POL    = 3'd1,
        SEL_LEVEL  = 3'd2,
        SEL_BOTH   = 3'd3,
        SEL_STATUS = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [BANK_W-1:0] enable;
        logic [BANK_W-1:0] pol;
        logic [BANK_W-1:0] level;
        logic [BANK_W-1:0] both;
    } bank_cfg_t;

    // Lines that signal an event for this sample pair.
    function automatic logic [BANK_W-1:0] detect_hits(
        input bank_cfg_t         cfg,
        input logic [BANK_W-1:0] cur,
        input logic [BANK_W-1:0] prev,
        input logic              primed
    );
        logic [BANK_W-1:0] rise, fall, edg, lvl;
        rise = cur & ~prev;
        fall = ~cur & prev;
        edg  = (cfg.both & (rise | fall))
             | (~cfg.both & ((cfg.pol & rise) | (~cfg.pol & fall)));
        if (!primed) edg = '0;
        lvl  = ~(cur ^ cfg.pol);
        return cfg.enable & ((cfg.level & lvl) | (~cfg.level & edg));
    endfunction
endpackage

// File: rtl/lid_sample_track.sv
module lid_sample_track #(
    parameter int LINES = 96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [LINES-1:0] cur,
    output logic [LINES-1:0] prev,
    output logic             primed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            primed <= 1'b0;
        end else if (valid) begin
            prev   <= cur;
            primed <= 1'b1;
        end
    end
endmodule

// File: rtl/lid_bank.sv
module lid_bank
    import lid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [BANK_W-1:0] wdata,
    input  logic              smp_valid,
    input  logic [BANK_W-1:0] cur,
    input  logic [BANK_W-1:0] prev,
    input  logic              primed,
    output bank_cfg_t         cfg,
    output logic [BANK_W-1:0] status
);
    logic [BANK_W-1:0] hits;
    logic [BANK_W-1:0] clr;

    always_comb begin
        hits = smp_valid ? detect_hits(cfg, cur, prev, primed) : '0;
        clr  = (wr_en && sel == SEL_STATUS) ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            status <= '0;
        end else begin
            if (wr_en) begin
                case (sel)
                    SEL_ENABLE: cfg.enable <= wdata;
                    SEL_POL:    cfg.pol    <= wdata;
                    SEL_LEVEL:  cfg.level  <= wdata;
                    SEL_BOTH:   cfg.both   <= wdata;
                    default:    ;
                endcase
            end
            // a fresh event outranks a clear in the same cycle
            status <= (status & ~clr) | hits;
        end
    end
endmodule

// File: rtl/line_irq_detector.sv
module line_irq_detector
    import lid_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    localparam int LINES      = NUM_BANKS * BANK_W,
    localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W     = BANK_IDX_W + REG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [LINES-1:0]  smp_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    output logic [BANK_W-1:0] reg_rdata,
    output logic              irq
);
    logic [LINES-1:0]      prev;
    logic                  primed;
    logic [LINES-1:0]      status_all;
    logic [LINES-1:0]      enable_all;
    bank_cfg_t             cfg [NUM_BANKS];
    logic [BANK_W-1:0]     st  [NUM_BANKS];
    logic [BANK_IDX_W-1:0] bank_idx;
    logic [2:0]            sel_raw;
    logic                  sel_ok;

    assign bank_idx = reg_addr[ADDR_W-1:REG_AW];
    assign sel_raw  = reg_addr[REG_AW-1:2];
    assign sel_ok   = (sel_raw <= 3'd4);

    lid_sample_track #(.LINES(LINES)) u_track (
        .clk    (clk),
        .rst    (rst),
        .valid  (smp_valid),
        .cur    (smp_data),
        .prev   (prev),
        .primed (primed)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_here;
        assign wr_here = reg_wr && sel_ok && (bank_idx == BANK_IDX_W'(b));

        lid_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_here),
            .sel       (reg_sel_e'(sel_raw)),
            .wdata     (reg_wdata),
            .smp_valid (smp_valid),
            .cur       (smp_data[b*BANK_W +: BANK_W]),
            .prev      (prev[b*BANK_W +: BANK_W]),
            .primed    (primed),
            .cfg       (cfg[b]),
            .status    (st[b])
        );

        assign status_all[b*BANK_W +: BANK_W] = st[b];
        assign enable_all[b*BANK_W +: BANK_W] = cfg[b].enable;
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_IDX_W'(b)) begin
                case (sel_raw)
                    3'd0:    reg_rdata = cfg[b].enable;
                    3'd1:    reg_rdata = cfg[b].pol;
                    3'd2:    reg_rdata = cfg[b].level;
                    3'd3:    reg_rdata = cfg[b].both;
                    3'd4:    reg_rdata = st[b];
                    default: reg_rdata = '0;
                endcase
            end
        end
    end

    assign irq = |(status_all & enable_all);
endmodule

// File: rtl/line_irq_detector_chk.sv
module line_irq_detector_chk #(
    parameter int LINES = 96
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic             irq,
    input logic [LINES-1:0] status_all,
    input logic [LINES-1:0] enable_all
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (status_all == '0 && enable_all == '0 && !irq));

    // R6
    no_set_while_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ((status_all & ~$past(status_all)) == '0));

    // R6
    no_set_when_masked_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> ((status_all & ~$past(status_all) & ~$past(enable_all)) == '0));

    // R9
    irq_quiet_no_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (enable_all == '0) |-> !irq);

    // R9
    irq_quiet_no_status_chk: assert property (@(posedge clk) disable iff (rst)
        (status_all == '0) |-> !irq);
endmodule

bind line_irq_detector line_irq_detector_chk #(.LINES(LINES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .irq        (irq),
    .status_all (status_all),
    .enable_all (enable_all)
);

// File: tb/line_irq_detector_test.sv
module line_irq_detector_test;
    localparam int NB    = 3;
    localparam int LINES = NB * 32;
    localparam int AW    = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_valid = 1'b0;
    logic [LINES-1:0] smp_data = '0;
    logic             reg_wr = 1'b0;
    logic [AW-1:0]    reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    line_irq_detector #(.NUM_BANKS(NB)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    // row: {line[6:0], pol, level, both, prev, cur, expected}
    localparam logic [12:0] TBL [10] = '{
        {7'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 falling seen
        {7'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 rise ignored
        {7'd33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 rising seen
        {7'd40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 fall ignored
        {7'd70, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R4 fall, pol 1
        {7'd64, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 rise, pol 0
        {7'd95, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 steady
        {7'd31, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 high level
        {7'd63, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 low level
        {7'd2,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}   // R5 inactive, both ignored
    };

    function automatic logic [AW-1:0] ad(input int bank, input int sel);
        return AW'(bank * 32 + sel * 4);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic smp(input logic [LINES-1:0] v);
        smp_data = v; smp_valid = 1'b1;
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        #1;
        do_reset();
        smp('0);  // prime reference (R10)

        for (int i = 0; i < 10; i++) begin
            int ln, bk, bt;
            logic [12:0] r;
            r  = TBL[i];
            ln = int'(r[12:6]); bk = ln / 32; bt = ln % 32;
            wr(ad(bk, 1), r[5] ? (32'd1 << bt) : 32'd0);
            wr(ad(bk, 2), r[4] ? (32'd1 << bt) : 32'd0);
            wr(ad(bk, 3), r[3] ? (32'd1 << bt) : 32'd0);
            wr(ad(bk, 0), 32'd1 << bt);
            smp(LINES'(r[2]) << ln);
            wr(ad(bk, 4), 32'hFFFF_FFFF);
            smp(LINES'(r[1]) << ln);
            rd(ad(bk, 4), d);
            check($sformatf("R3/R4/R5 row %0d", i), {31'd0, d[bt]}, {31'd0, r[0]});
            wr(ad(bk, 0), 32'd0);
            wr(ad(bk, 4), 32'hFFFF_FFFF);
        end

        // R1: reset state
        do_reset();
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < 5; s++) begin
                rd(ad(b, s), d);
                check("R1 reset register", d, 32'd0);
            end
        check("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R10: first sample only primes
        wr(ad(0, 1), 32'h8);
        wr(ad(0, 0), 32'h8);
        smp(LINES'(8));
        rd(ad(0, 4), d);
        check("R10 no edge on first sample", d, 32'd0);
        smp('0);
        smp(LINES'(8));
        rd(ad(0, 4), d);
        check("R3 rising after priming", d, 32'h8);
        check("R9 irq raised", {31'd0, irq}, 32'd1);

        // R7: write-one-to-clear
        wr(ad(0, 4), 32'd0);
        rd(ad(0, 4), d);
        check("R7 zero write keeps status", d, 32'h8);
        wr(ad(0, 4), 32'h8);
        rd(ad(0, 4), d);
        check("R7 one write clears", d, 32'd0);
        check("R9 irq drops", {31'd0, irq}, 32'd0);

        // R6: no strobe, no event; disabled line, no event
        smp_data = '0; tick(); smp_data = LINES'(8); tick();
        smp('0);
        rd(ad(0, 4), d);
        check("R6 unstrobed change ignored", d, 32'd0);
        wr(ad(0, 0), 32'd0);
        smp(LINES'(8));
        rd(ad(0, 4), d);
        check("R6 disabled line ignored", d, 32'd0);

        // R8: detection beats clear in the same cycle (bank 2, line 10, level high)
        wr(ad(2, 1), 32'h400);
        wr(ad(2, 2), 32'h400);
        wr(ad(2, 0), 32'h400);
        smp(LINES'(1) << 74);
        rd(ad(2, 4), d);
        check("R5 level sets", d, 32'h400);
        reg_addr = ad(2, 4); reg_wdata = 32'h400; reg_wr = 1'b1;
        smp_data = LINES'(1) << 74; smp_valid = 1'b1;
        tick();
        reg_wr = 1'b0; smp_valid = 1'b0;
        rd(ad(2, 4), d);
        check("R8 event wins over clear", d, 32'h400);
        reg_addr = ad(2, 4); reg_wdata = 32'h400; reg_wr = 1'b1;
        smp_data = '0; smp_valid = 1'b1;
        tick();
        reg_wr = 1'b0; smp_valid = 1'b0;
        rd(ad(2, 4), d);
        check("R8 clear with inactive sample", d, 32'd0);

        // R9: enable masks irq, status kept
        smp(LINES'(1) << 74);
        check("R9 irq from bank 2", {31'd0, irq}, 32'd1);
        wr(ad(2, 0), 32'd0);
        check("R9 irq masked", {31'd0, irq}, 32'd0);
        rd(ad(2, 4), d);
        check("R9 status kept while masked", d, 32'h400);

        // R2: readback and unmapped offsets
        wr(ad(1, 1), 32'hA5A5_0F0F);
        rd(ad(1, 1), d);
        check("R2 readback polarity", d, 32'hA5A5_0F0F);
        wr(ad(1, 5), 32'hFFFF_FFFF);
        rd(ad(1, 5), d);
        check("R2 unmapped offset", d, 32'd0);
        wr(ad(3, 0), 32'hFFFF_FFFF);
        rd(ad(3, 0), d);
        check("R2 absent bank", d, 32'd0);
        rd(ad(1, 0), d);
        check("R2 absent bank write no alias", d, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule